// File: doc/BRIEF.md
# Comma-Detecting Serial Word Aligner

This block sits on a recovered-clock serial path, after clock and data recovery. It takes one bit per clock, qualified by a valid strobe, and cuts the stream into 10-bit transmission characters. It finds word boundaries by looking for a seven-bit comma. That comma occurs only inside the special control characters, so a match marks a real character boundary.

Either polarity of the comma is accepted. The arrival order 0,0,1,1,1,1,1 is found, and so is its complement 1,1,0,0,0,0,0, which covers both running-disparity forms. On a match the block sets the character boundary so that the earliest comma bit lands in output bit 0. It then emits one word every ten valid bits. Each word carries a flag that marks a comma in its low seven bits. A one-cycle pulse reports each time the boundary is set. A status output stays high from the first comma onward. Everything runs in the recovered-clock domain.

Top module: `serial_word_aligner`

## Requirements
- R1: While `rst_n` is low and on the first edge after its release, `word_vld`, `comma_flag`, `realign` and `aligned` are all 0.
- R2: Before the first comma after reset, `word_vld` stays 0 and `aligned` stays 0, whatever the bits are.
- R3: Once aligned, a character is complete when the tenth valid bit counted from its boundary arrives. In the cycle after that bit is sampled, `word_vld` is 1 for exactly one cycle. In that word, `word_out[i]` is the i-th bit of the character in order of arrival, with bit 0 the earliest. A comma sets the boundary at its own first bit.
- R4: The comma is matched on the last seven valid bits in both polarities. In `word_out` terms these are low bits 7'b1111100 (arrival 0,0,1,1,1,1,1) and 7'b0000011 (arrival 1,1,0,0,0,0,0).
- R5: `comma_flag` is 1 together with `word_vld` exactly when `word_out[6:0]` equals 7'b1111100 or 7'b0000011. It is 0 in every other cycle.
- R6: A comma may end at a bit offset that differs from the current boundary. In that case `realign` pulses one cycle after its last bit, the count restarts from that comma, and the partial character is dropped without a `word_vld`.
- R7: A comma that falls on the current boundary causes no `realign` pulse and leaves the word cadence unchanged.
- R8: A cycle with `bit_vld` low shifts no bit and advances no count. In the following cycle `word_vld`, `comma_flag` and `realign` are 0.
- R9: Once `aligned` is 1, it stays 1 until reset.
- R10: The first comma after reset also produces a `realign` pulse, in the same cycle that `aligned` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| word_out | output | 10 | Aligned character, bit 0 earliest received |
| word_vld | output | 1 | One-cycle pulse when `word_out` holds a new character |
| comma_flag | output | 1 | Current word carries a comma in its low seven bits |
| realign | output | 1 | One-cycle pulse when the boundary is (re)set by a comma |
| aligned | output | 1 | A comma has been seen since reset |

## Verification
A comma-free alternating pattern shows that nothing is emitted before lock. A run of negative-disparity and positive-disparity K28.5 characters checks the bit placement, both comma polarities and the absence of spurious realigns at a steady boundary. Three slip bits inserted before a further comma force a mid-character realign and show that the partial word is dropped. A long seeded random stream with random idle gaps then drives commas at arbitrary offsets. A bench model that tracks bit indices and comma anchors predicts every output in each cycle of that stream.

// File: rtl/sal_pkg.sv
package sal_pkg;
    localparam int CHAR_W  = 10;
    localparam int COMMA_W = 7;
    localparam int CNT_W   = $clog2(CHAR_W + 1);

    // comma in word-bit order (bit 0 = earliest arrival): 0,0,1,1,1,1,1
    localparam logic [COMMA_W-1:0] COMMA_POS = 7'b1111100;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic [CHAR_W-1:0] word;
        logic              word_vld;
        logic              comma;
        logic              realign;
        logic              aligned;
        cnt_t              cnt;
    } frm_state_t;
endpackage

// File: rtl/sal_window.sv
module sal_window
    import sal_pkg::*;
#(
    parameter int W = CHAR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_in,
    input  logic         shift_en,
    output logic [W-1:0] win_d_o
);
    logic [W-1:0] win_d, win_q;

    // newest bit enters at the top; the oldest bit sits at index 0
    always_comb begin
        win_d = win_q;
        if (shift_en) win_d = {bit_in, win_q[W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign win_d_o = win_d;
endmodule

// File: rtl/sal_comma_match.sv
module sal_comma_match
    import sal_pkg::*;
#(
    parameter int               W   = CHAR_W,
    parameter int               CW  = COMMA_W,
    parameter logic [CW-1:0]    PAT = COMMA_POS
) (
    input  logic [W-1:0] win,
    output logic         hit_tail,
    output logic         hit_low
);
    logic [1:0] tail_m, low_m;

    // index 0: plain polarity, index 1: complemented polarity
    for (genvar p = 0; p < 2; p++) begin : g_pol
        localparam logic [CW-1:0] PV = (p == 0) ? PAT : ~PAT;
        assign tail_m[p] = (win[W-1 -: CW] == PV);
        assign low_m[p]  = (win[CW-1:0] == PV);
    end

    assign hit_tail = |tail_m;
    assign hit_low  = |low_m;
endmodule

// File: rtl/sal_framer.sv
module sal_framer
    import sal_pkg::*;
#(
    parameter int W  = CHAR_W,
    parameter int CW = COMMA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic [W-1:0] win,
    input  logic         hit_tail,
    input  logic         hit_low,
    output logic [W-1:0] word_o,
    output logic         word_vld_o,
    output logic         comma_o,
    output logic         realign_o,
    output logic         aligned_o
);
    localparam cnt_t CNT_COMMA = cnt_t'(CW);
    localparam cnt_t CNT_FULL  = cnt_t'(W);

    frm_state_t s_d, s_q;
    cnt_t       cnt_inc;

    always_comb begin
        s_d          = s_q;
        s_d.word_vld = 1'b0;
        s_d.comma    = 1'b0;
        s_d.realign  = 1'b0;
        cnt_inc      = s_q.cnt + cnt_t'(1);
        if (shift_en) begin
            if (hit_tail) begin
                // boundary moves to the comma's first bit; partial word dropped
                s_d.realign = !s_q.aligned || (cnt_inc != CNT_COMMA);
                s_d.aligned = 1'b1;
                s_d.cnt     = CNT_COMMA;
            end else if (s_q.aligned) begin
                if (cnt_inc == CNT_FULL) begin
                    s_d.word     = win;
                    s_d.word_vld = 1'b1;
                    s_d.comma    = hit_low;
                    s_d.cnt      = '0;
                end else begin
                    s_d.cnt = cnt_inc;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word_o     = s_q.word;
    assign word_vld_o = s_q.word_vld;
    assign comma_o    = s_q.comma;
    assign realign_o  = s_q.realign;
    assign aligned_o  = s_q.aligned;
endmodule

// File: rtl/serial_word_aligner.sv
module serial_word_aligner
    import sal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_vld,
    output logic [CHAR_W-1:0] word_out,
    output logic              word_vld,
    output logic              comma_flag,
    output logic              realign,
    output logic              aligned
);
    logic [CHAR_W-1:0] win_d;
    logic              hit_tail, hit_low;

    sal_window #(.W(CHAR_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_in   (bit_in),
        .shift_en (bit_vld),
        .win_d_o  (win_d)
    );

    sal_comma_match #(.W(CHAR_W), .CW(COMMA_W), .PAT(COMMA_POS)) u_match (
        .win      (win_d),
        .hit_tail (hit_tail),
        .hit_low  (hit_low)
    );

    sal_framer #(.W(CHAR_W), .CW(COMMA_W)) u_frm (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (bit_vld),
        .win        (win_d),
        .hit_tail   (hit_tail),
        .hit_low    (hit_low),
        .word_o     (word_out),
        .word_vld_o (word_vld),
        .comma_o    (comma_flag),
        .realign_o  (realign),
        .aligned_o  (aligned)
    );
endmodule

// File: rtl/sal_checker.sv
module sal_checker
    import sal_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bit_vld,
    input logic [CHAR_W-1:0] word_out,
    input logic              word_vld,
    input logic              comma_flag,
    input logic              realign,
    input logic              aligned
);
    p_no_word_unlocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> aligned);

    p_word_from_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld || realign) |-> $past(bit_vld));

    p_comma_in_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        comma_flag |-> (word_vld &&
            (word_out[COMMA_W-1:0] == COMMA_POS || word_out[COMMA_W-1:0] == ~COMMA_POS)));

    p_realign_drops_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        realign |-> !word_vld);

    p_aligned_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        aligned |=> aligned);

    p_first_lock_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aligned) |-> realign);
endmodule

bind serial_word_aligner sal_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_vld    (bit_vld),
    .word_out   (word_out),
    .word_vld   (word_vld),
    .comma_flag (comma_flag),
    .realign    (realign),
    .aligned    (aligned)
);

// File: tb/serial_word_aligner_tb_top.sv
module serial_word_aligner_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b0;
    logic       bit_vld = 1'b0;
    logic [9:0] word_out;
    logic       word_vld, comma_flag, realign, aligned;

    always #4 clk = ~clk;   // 125 MHz

    serial_word_aligner dut_i (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .word_out(word_out), .word_vld(word_vld), .comma_flag(comma_flag),
        .realign(realign), .aligned(aligned)
    );

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    // reference model state
    logic [9:0] m_win = '0;
    bit  m_al = 1'b0;
    int  m_n = 0, m_anchor = 0;
    bit  e_vld, e_comma, e_realign, e_first;
    logic [9:0] e_word = '0;
    int  n_realign = 0;
    bit  seen_neg = 1'b0, seen_pos = 1'b0;

    // K28.5 in arrival order, index 0 sent first
    localparam logic [9:0] K_NEG = 10'b0101111100;
    localparam logic [9:0] K_POS = ~K_NEG;

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit is_comma7(input logic [6:0] v);
        return (v == 7'b1111100) || (v == 7'b0000011);
    endfunction

    task automatic model(input logic b, input logic v);
        e_vld = 0; e_comma = 0; e_realign = 0; e_first = 0;
        if (v) begin
            m_n++;
            m_win = {b, m_win[9:1]};
            if (is_comma7(m_win[9:3])) begin
                int start = m_n - 6;
                e_first   = !m_al;
                e_realign = !m_al || (((start - m_anchor) % 10) != 0);
                m_anchor  = start;
                m_al      = 1;
            end else if (m_al && (((m_n - m_anchor + 1) % 10) == 0)) begin
                e_vld   = 1;
                e_word  = m_win;
                e_comma = is_comma7(m_win[6:0]);
            end
        end
    endtask

    task automatic step(input logic b, input logic v);
        @(negedge clk);
        bit_in = b; bit_vld = v;
        model(b, v);
        @(posedge clk); #1;
        chk(v ? "R3 word_vld" : "R8 word_vld idle", {9'b0, word_vld}, {9'b0, e_vld});
        if (e_vld) begin
            chk("R3 word_out", word_out, e_word);
            chk("R5 comma_flag", {9'b0, comma_flag}, {9'b0, e_comma});
            if (word_out == K_NEG) seen_neg = 1;
            if (word_out == K_POS) seen_pos = 1;
        end else begin
            chk("R5 comma_flag idle", {9'b0, comma_flag}, 10'd0);
        end
        chk(e_first ? "R10 realign" : (v ? "R6 realign" : "R8 realign idle"),
            {9'b0, realign}, {9'b0, e_realign});
        chk(m_al ? "R9 aligned" : "R2 aligned", {9'b0, aligned}, {9'b0, m_al});
        if (realign) n_realign++;
    endtask

    task automatic send_char(input logic [9:0] c);
        for (int i = 0; i < 10; i++) step(c[i], 1'b1);
    endtask

    initial begin
        void'($urandom(32'd2468));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset outputs", {6'b0, word_vld, comma_flag, realign, aligned}, 10'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 after release", {6'b0, word_vld, comma_flag, realign, aligned}, 10'd0);

        // R2: comma-free alternating pattern
        for (int i = 0; i < 40; i++) step(i[0], 1'b1);
        chk("R2 still unlocked", {9'b0, aligned}, 10'd0);

        // R3/R10: first lock on negative-form K28.5, then steady K28.5 stream
        send_char(K_NEG);
        n_realign = 0;
        for (int i = 0; i < 4; i++) send_char(K_NEG);
        chk("R7 no realign at steady boundary", 10'(n_realign), 10'd0);
        chk("R3 K28.5 placement seen", {9'b0, seen_neg}, 10'd1);

        // R4: positive-disparity form, same boundary
        n_realign = 0;
        for (int i = 0; i < 3; i++) send_char(K_POS);
        chk("R4 complement form seen", {9'b0, seen_pos}, 10'd1);
        chk("R7 no realign across polarity", 10'(n_realign), 10'd0);

        // R6: three slip bits, then a comma at a new offset
        step(1'b1, 1'b1); step(1'b0, 1'b1); step(1'b1, 1'b1);
        n_realign = 0;
        send_char(K_NEG);
        chk("R6 realign on slip", 10'(n_realign), 10'd1);
        send_char(K_POS);

        // R8 and random: random bits with random idle gaps
        for (int i = 0; i < 6000; i++) begin
            logic v = ($urandom % 4) != 0;
            step(logic'($urandom % 2), v);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule